// File: doc/BRIEF.md
# Divided-Input Clock Selector

This block forms one clock output from three source clocks. Each source first passes through its own divider. The output then follows exactly one divided source, or it is held low. Software works through a small register port on a separate register clock. It stores a source index, sets the three divider ratios, and issues enable and disable commands. It can then watch a per-source running flag, which shows when the output has really moved to the chosen source.

An enable copies the stored index into a two-bit select field. It then waits for the chosen path to report that it is running. If that report does not come within a set number of register-clock cycles, an error flag is raised. The hand-over from one path to the next is done by a synchronised gate in each path's own clock domain. The old path lets go on its own low phase, and only then does the new path open, also on its low phase. No shortened pulse reaches the output.

Top module: `div_clk_selector`

## Requirements
- R1: After reset the select field (CTL bits 1:0, address 1) reads 3 (output off), the stored index (address 0, bits 1:0) reads 0, all three divider registers read 0, the error and busy flags (CTL bits 6 and 7) read 0, the running flags read 0, and clk_out stays low.
- R2: Divider register i (address 2+i, bits 4:0) holds a value N, reads it back, and makes source i reach the output with a period of N+1 source periods; a value of 0 passes the source through undivided.
- R3: A write to address 0 with a code of 0, 1 or 2 in bits 1:0 stores that index; a code of 3 is rejected and the stored index keeps its old value.
- R4: Writing address 1 with bit 0 set copies the stored index into the select field and sets busy (CTL bit 7); busy clears once the running flag of the selected source reads 1.
- R5: If that running flag is not seen within TIMEOUT_CYC register-clock cycles of the enable, busy clears and the error flag (CTL bit 6) is set; the next enable clears the error flag.
- R6: A valid write to address 0 while the select field holds 1 or 2 re-runs the enable sequence with the new index; while the field holds 0 or 3, the write only records the index, and the field and busy stay as they were.
- R7: Writing address 1 with bit 1 set puts 3 into the select field and clears busy, and this takes priority over bit 0 in the same write; clk_out then stays low, and all running flags fall to 0.
- R8: clk_out never shows a high or low phase shorter than the shortest half-period of any divided source, and at most one path is active at any instant.
- R9: Address 5 bit i reads 1 exactly while path i drives the output; it is carried into the register clock domain through two flops.
- R10: A read strobe on address 1 while the select field holds 3 resets the stored index to 0, unless a register write happens in the same cycle; in that case the write takes effect and the default is skipped.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset, all domains |
| src_clk | input | N_SRC | Source clocks, one per path |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 3 | Write address |
| reg_wdata | input | 8 | Write data |
| reg_re | input | 1 | Read strobe (only side effect: the R10 default) |
| reg_raddr | input | 3 | Read address |
| reg_rdata | output | 8 | Read data, combinational from reg_raddr |
| clk_out | output | 1 | Selected, divided and gated clock |

## Verification
Two events can land in the same register-clock cycle, and the bench forces both of them. In the first, the bench pulses a read strobe on the select register while the output is off, and in that same cycle it writes a valid source index. The bench then reads back the stored index: it must hold the written value, not the default 0. A second read strobe on its own must then clear the index to 0. In the second, the bench sends a burst of source writes while a switch is still in progress. It then checks that the final path settles with the right period, that no short pulse appears on clk_out, and that two paths are never active together.

// File: rtl/clksel_pkg.sv
`timescale 1ns/1ps
package clksel_pkg;
    localparam int unsigned REG_AW = 3;
    localparam int unsigned REG_DW = 8;
    localparam int unsigned SEL_W  = 2;

    localparam logic [REG_AW-1:0] ADDR_SRC      = 3'd0;
    localparam logic [REG_AW-1:0] ADDR_CTL      = 3'd1;
    localparam logic [REG_AW-1:0] ADDR_DIV_BASE = 3'd2;
    localparam logic [REG_AW-1:0] ADDR_RUN      = 3'd5;

    localparam logic [SEL_W-1:0] SEL_OFF = 2'd3;

    localparam int unsigned CTL_EN_BIT   = 0;
    localparam int unsigned CTL_DIS_BIT  = 1;
    localparam int unsigned CTL_ERR_BIT  = 6;
    localparam int unsigned CTL_BUSY_BIT = 7;
endpackage

// File: rtl/clksel_sync.sv
`timescale 1ns/1ps
module clksel_sync #(
    parameter int unsigned W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_t;

    sync_t sync_d, sync_q;

    always_comb begin
        sync_d    = sync_q;
        sync_d.s1 = async_in;
        sync_d.s2 = sync_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign sync_out = sync_q.s2;
endmodule

// File: rtl/clksel_div.sv
`timescale 1ns/1ps
module clksel_div #(
    parameter int unsigned DIV_W = 5
) (
    input  logic             src_clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] ratio,
    output logic             div_clk
);
    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             ph;
    } div_t;

    div_t div_d, div_q;
    logic [DIV_W-1:0] cnt_nxt;
    logic [DIV_W:0]   hi_len;

    always_comb begin
        div_d   = div_q;
        cnt_nxt = (div_q.cnt >= ratio) ? '0 : div_q.cnt + 1'b1;
        // high phase lasts ceil((ratio+1)/2) source cycles
        hi_len  = ({1'b0, ratio} + (DIV_W+1)'(2)) >> 1;
        div_d.cnt = cnt_nxt;
        div_d.ph  = ({1'b0, cnt_nxt} < hi_len);
    end

    always_ff @(posedge src_clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    // ratio 0: bypass, the source itself is the divided clock
    assign div_clk = (ratio == '0) ? src_clk : div_q.ph;
endmodule

// File: rtl/clksel_gate.sv
`timescale 1ns/1ps
module clksel_gate (
    input  logic div_clk,
    input  logic rst_n,
    input  logic req,
    input  logic others_busy,
    output logic act,
    output logic busy,
    output logic gclk
);
    typedef struct packed {
        logic s1;
        logic s2;
    } gate_t;

    gate_t gate_d, gate_q;

    always_comb begin
        gate_d    = gate_q;
        gate_d.s1 = req & ~others_busy;
        gate_d.s2 = gate_q.s1;
    end

    // falling-edge stages: enable changes only while div_clk is low
    always_ff @(negedge div_clk or negedge rst_n) begin
        if (!rst_n) gate_q <= '0;
        else        gate_q <= gate_d;
    end

    assign act  = gate_q.s2;
    assign busy = gate_q.s1 | gate_q.s2;
    assign gclk = div_clk & gate_q.s2;
endmodule

// File: rtl/clksel_ctrl.sv
`timescale 1ns/1ps
module clksel_ctrl
    import clksel_pkg::*;
#(
    parameter int unsigned N_SRC       = 3,
    parameter int unsigned DIV_W       = 5,
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   reg_we,
    input  logic [REG_AW-1:0]      reg_waddr,
    input  logic [REG_DW-1:0]      reg_wdata,
    input  logic                   reg_re,
    input  logic [REG_AW-1:0]      reg_raddr,
    input  logic [N_SRC-1:0]       run_sync,
    output logic [REG_DW-1:0]      reg_rdata,
    output logic [SEL_W-1:0]       sel_field,
    output logic [SEL_W-1:0]       src_idx,
    output logic                   busy,
    output logic                   err,
    output logic [N_SRC*DIV_W-1:0] div_flat
);
    localparam int unsigned TW = $clog2(TIMEOUT_CYC + 1);

    typedef struct packed {
        logic [SEL_W-1:0]       idx;
        logic [SEL_W-1:0]       field;
        logic                   busy;
        logic                   err;
        logic [TW-1:0]          tcnt;
        logic [N_SRC*DIV_W-1:0] divs;
    } ctl_t;

    ctl_t ctl_d, ctl_q;
    logic wr_src, wr_ctl, src_ok, live, start, run_hit;
    logic unused_wbits;

    assign unused_wbits = ^reg_wdata[REG_DW-1:DIV_W];

    always_comb begin
        ctl_d   = ctl_q;
        start   = 1'b0;
        wr_src  = reg_we && (reg_waddr == ADDR_SRC);
        wr_ctl  = reg_we && (reg_waddr == ADDR_CTL);
        src_ok  = (reg_wdata[SEL_W-1:0] != SEL_OFF);
        live    = (ctl_q.field != '0) && (ctl_q.field != SEL_OFF);
        run_hit = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (ctl_q.field == SEL_W'(i)) run_hit = run_sync[i];
        end

        // invalid select read-back: default the stored index
        if (reg_re && !reg_we && (reg_raddr == ADDR_CTL) && (ctl_q.field == SEL_OFF))
            ctl_d.idx = '0;

        if (wr_src && src_ok) begin
            ctl_d.idx = reg_wdata[SEL_W-1:0];
            start     = live;
        end
        if (wr_ctl && reg_wdata[CTL_EN_BIT]) start = 1'b1;

        for (int i = 0; i < N_SRC; i++) begin
            if (reg_we && (reg_waddr == ADDR_DIV_BASE + REG_AW'(i)))
                ctl_d.divs[i*DIV_W +: DIV_W] = reg_wdata[DIV_W-1:0];
        end

        if (ctl_q.busy) begin
            if (run_hit) begin
                ctl_d.busy = 1'b0;
            end else if (ctl_q.tcnt == TW'(TIMEOUT_CYC - 1)) begin
                ctl_d.busy = 1'b0;
                ctl_d.err  = 1'b1;
            end else begin
                ctl_d.tcnt = ctl_q.tcnt + 1'b1;
            end
        end

        if (start) begin
            ctl_d.field = ctl_d.idx;
            ctl_d.busy  = 1'b1;
            ctl_d.err   = 1'b0;
            ctl_d.tcnt  = '0;
        end

        if (wr_ctl && reg_wdata[CTL_DIS_BIT]) begin
            ctl_d.field = SEL_OFF;
            ctl_d.busy  = 1'b0;
            ctl_d.tcnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.field <= SEL_OFF;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            ADDR_SRC: reg_rdata[SEL_W-1:0] = ctl_q.idx;
            ADDR_CTL: begin
                reg_rdata[SEL_W-1:0]    = ctl_q.field;
                reg_rdata[CTL_ERR_BIT]  = ctl_q.err;
                reg_rdata[CTL_BUSY_BIT] = ctl_q.busy;
            end
            ADDR_RUN: reg_rdata[N_SRC-1:0] = run_sync;
            default: begin
                for (int i = 0; i < N_SRC; i++) begin
                    if (reg_raddr == ADDR_DIV_BASE + REG_AW'(i))
                        reg_rdata[DIV_W-1:0] = ctl_q.divs[i*DIV_W +: DIV_W];
                end
            end
        endcase
    end

    assign sel_field = ctl_q.field;
    assign src_idx   = ctl_q.idx;
    assign busy      = ctl_q.busy;
    assign err       = ctl_q.err;
    assign div_flat  = ctl_q.divs;
endmodule

// File: rtl/div_clk_selector.sv
`timescale 1ns/1ps
module div_clk_selector
    import clksel_pkg::*;
#(
    parameter int unsigned N_SRC       = 3,
    parameter int unsigned DIV_W       = 5,
    parameter int unsigned TIMEOUT_CYC = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_clk,
    input  logic              reg_we,
    input  logic [2:0]        reg_waddr,
    input  logic [7:0]        reg_wdata,
    input  logic              reg_re,
    input  logic [2:0]        reg_raddr,
    output logic [7:0]        reg_rdata,
    output logic              clk_out
);
    logic [SEL_W-1:0]       sel_field;
    logic [SEL_W-1:0]       src_idx;
    logic                   busy;
    logic                   err;
    logic [N_SRC*DIV_W-1:0] div_flat;
    logic [N_SRC-1:0]       run_sync;
    logic [N_SRC-1:0]       act_vec;
    logic [N_SRC-1:0]       busy_vec;
    logic [N_SRC-1:0]       gclk_vec;
    logic [N_SRC-1:0]       div_clk_vec;

    clksel_ctrl #(
        .N_SRC(N_SRC), .DIV_W(DIV_W), .TIMEOUT_CYC(TIMEOUT_CYC)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_re(reg_re), .reg_raddr(reg_raddr),
        .run_sync(run_sync), .reg_rdata(reg_rdata),
        .sel_field(sel_field), .src_idx(src_idx),
        .busy(busy), .err(err), .div_flat(div_flat)
    );

    for (genvar g = 0; g < N_SRC; g++) begin : g_path
        logic req;
        logic others;
        assign req    = (sel_field == SEL_W'(g));
        assign others = |(busy_vec & ~(N_SRC'(1) << g));

        clksel_div #(.DIV_W(DIV_W)) u_div (
            .src_clk(src_clk[g]), .rst_n(rst_n),
            .ratio(div_flat[g*DIV_W +: DIV_W]), .div_clk(div_clk_vec[g])
        );

        clksel_gate u_gate (
            .div_clk(div_clk_vec[g]), .rst_n(rst_n),
            .req(req), .others_busy(others),
            .act(act_vec[g]), .busy(busy_vec[g]), .gclk(gclk_vec[g])
        );
    end

    clksel_sync #(.W(N_SRC)) u_run_sync (
        .clk(clk), .rst_n(rst_n), .async_in(act_vec), .sync_out(run_sync)
    );

    assign clk_out = |gclk_vec;
endmodule

// File: rtl/clksel_chk.sv
`timescale 1ns/1ps
module clksel_chk
    import clksel_pkg::*;
#(
    parameter int unsigned N_SRC = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             reg_we,
    input logic [2:0]       reg_waddr,
    input logic [7:0]       reg_wdata,
    input logic [1:0]       sel_field,
    input logic [1:0]       src_idx,
    input logic             busy,
    input logic             err,
    input logic [N_SRC-1:0] act_vec,
    input logic [N_SRC-1:0] run_sync
);
    logic run_hit;
    always_comb begin
        run_hit = 1'b0;
        for (int i = 0; i < N_SRC; i++)
            if (sel_field == 2'(i)) run_hit = run_sync[i];
    end

    p_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == ADDR_SRC && reg_wdata[1:0] == SEL_OFF)
        |=> src_idx == $past(src_idx));

    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == ADDR_SRC && reg_wdata[1:0] != SEL_OFF)
        |=> src_idx == $past(reg_wdata[1:0]));

    p_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && run_hit && !reg_we) |=> !busy);

    p_timeout_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err) |-> $past(busy));

    p_off_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_field == SEL_OFF) |-> !busy);

    p_disable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_waddr == ADDR_CTL && reg_wdata[CTL_DIS_BIT])
        |=> (sel_field == SEL_OFF && !busy));

    p_one_path_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(act_vec));
endmodule

bind div_clk_selector clksel_chk #(.N_SRC(N_SRC)) u_chk (
    .clk(clk), .rst_n(rst_n),
    .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
    .sel_field(sel_field), .src_idx(src_idx),
    .busy(busy), .err(err), .act_vec(act_vec), .run_sync(run_sync)
);

// File: tb/test_div_clk_selector.sv
`timescale 1ns/1ps
module test_div_clk_selector;
    localparam int TMO = 300;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] src_clk = 3'b000;
    logic [2:0] src_en = 3'b111;
    logic       reg_we = 1'b0;
    logic [2:0] reg_waddr = '0;
    logic [7:0] reg_wdata = '0;
    logic       reg_re = 1'b0;
    logic [2:0] reg_raddr = '0;
    logic [7:0] reg_rdata;
    logic       clk_out;

    int n_chk = 0;
    int n_bad = 0;
    int glitches = 0;
    realtime t_last = 0.0;

    div_clk_selector #(.N_SRC(3), .DIV_W(5), .TIMEOUT_CYC(TMO)) i_div_clk_selector (
        .clk(clk), .rst_n(rst_n), .src_clk(src_clk),
        .reg_we(reg_we), .reg_waddr(reg_waddr), .reg_wdata(reg_wdata),
        .reg_re(reg_re), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .clk_out(clk_out)
    );

    always #5 clk = ~clk;
    initial begin #0.7; forever begin #4;  if (src_en[0]) src_clk[0] = ~src_clk[0]; end end
    initial begin #1.9; forever begin #7;  if (src_en[1]) src_clk[1] = ~src_clk[1]; end end
    initial begin #2.3; forever begin #11; if (src_en[2]) src_clk[2] = ~src_clk[2]; end end

    // short-phase monitor for R8
    always @(clk_out) begin
        if (rst_n) begin
            if (($realtime - t_last) > 0.01 && ($realtime - t_last) < 3.9) glitches++;
        end
        t_last = $realtime;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_waddr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        @(negedge clk);
        reg_raddr = a;
        #1 v = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int k = 0; k < 200; k++) begin
            peek(3'd1, v);
            if (!v[7]) break;
        end
    endtask

    task automatic measure(input string req, input real exp);
        realtime t0, p;
        repeat (3) @(posedge clk_out);
        t0 = $realtime;
        @(posedge clk_out);
        p = $realtime - t0;
        n_chk++;
        if (p < exp - 0.5 || p > exp + 0.5) begin
            n_bad++;
            $display("FAIL %s: period got %0.2f expected %0.2f", req, p, exp);
        end
    endtask

    task automatic t_reset();
        logic [7:0] v;
        peek(3'd0, v); chk("R1 index", int'(v), 0);
        peek(3'd1, v); chk("R1 ctl", int'(v), 3);
        for (int i = 0; i < 3; i++) begin
            peek(3'(2 + i), v); chk("R1 divider", int'(v), 0);
        end
        peek(3'd5, v); chk("R1 running", int'(v), 0);
        for (int k = 0; k < 50; k++) begin
            #3 if (clk_out) begin chk("R1 clk_out low", 1, 0); break; end
        end
    endtask

    task automatic t_index();
        logic [7:0] v;
        wr(3'd0, 8'd2); peek(3'd0, v); chk("R3 store 2", int'(v), 2);
        wr(3'd0, 8'd3); peek(3'd0, v); chk("R3 reject 3", int'(v), 2);
        wr(3'd0, 8'd1); peek(3'd0, v); chk("R3 store 1", int'(v), 1);
    endtask

    task automatic t_enable();
        logic [7:0] v;
        wr(3'd2, 8'd1); wr(3'd3, 8'd3); wr(3'd4, 8'd0);
        peek(3'd3, v); chk("R2 readback", int'(v), 3);
        wr(3'd1, 8'h01);
        peek(3'd1, v); chk("R4 busy after enable", int'(v), 8'h81);
        wait_idle();
        peek(3'd1, v); chk("R4 done field 1", int'(v), 1);
        peek(3'd5, v); chk("R9 running path 1", int'(v), 3'b010);
        measure("R2 src1 div 4", 56.0);
    endtask

    task automatic t_change();
        logic [7:0] v;
        wr(3'd0, 8'd2);
        peek(3'd1, v); chk("R6 live change restarts", int'(v), 8'h82);
        wait_idle();
        peek(3'd5, v); chk("R9 running path 2", int'(v), 3'b100);
        measure("R2 src2 bypass", 22.0);
        wr(3'd0, 8'd0); wait_idle();
        peek(3'd1, v); chk("R6 switch to 0", int'(v), 0);
        measure("R2 src0 div 2", 16.0);
        wr(3'd0, 8'd1);
        peek(3'd1, v); chk("R6 field 0 only records", int'(v), 0);
        peek(3'd0, v); chk("R6 index recorded", int'(v), 1);
        measure("R6 output unchanged", 16.0);
    endtask

    task automatic t_disable();
        logic [7:0] v;
        wr(3'd1, 8'h03);
        peek(3'd1, v); chk("R7 off, disable wins", int'(v), 3);
        repeat (20) @(negedge clk);
        peek(3'd5, v); chk("R7 running cleared", int'(v), 0);
        for (int k = 0; k < 300; k++) begin
            #1 if (clk_out) begin chk("R7 clk_out quiet", 1, 0); break; end
        end
    endtask

    task automatic t_read_default();
        logic [7:0] v;
        @(negedge clk);
        reg_re = 1'b1; reg_raddr = 3'd1;
        reg_we = 1'b1; reg_waddr = 3'd0; reg_wdata = 8'd2;
        @(negedge clk);
        reg_re = 1'b0; reg_we = 1'b0;
        peek(3'd0, v); chk("R10 write beats default", int'(v), 2);
        @(negedge clk); reg_re = 1'b1; reg_raddr = 3'd1;
        @(negedge clk); reg_re = 1'b0;
        peek(3'd0, v); chk("R10 read defaults index", int'(v), 0);
    endtask

    task automatic t_timeout();
        logic [7:0] v;
        src_en[2] = 1'b0;
        wr(3'd0, 8'd2);
        wr(3'd1, 8'h01);
        repeat (TMO - 20) @(negedge clk);
        peek(3'd1, v); chk("R5 still waiting", int'(v), 8'h82);
        repeat (40) @(negedge clk);
        peek(3'd1, v); chk("R5 timeout error", int'(v), 8'h42);
        peek(3'd5, v); chk("R9 stopped source not running", int'(v), 0);
        src_en[2] = 1'b1;
        repeat (20) @(negedge clk);
        wr(3'd1, 8'h01); wait_idle();
        peek(3'd1, v); chk("R5 error cleared", int'(v), 2);
        measure("R5 recovered src2", 22.0);
    endtask

    task automatic t_burst();
        logic [7:0] v;
        wr(3'd0, 8'd1); wr(3'd0, 8'd2); wr(3'd0, 8'd1);
        wait_idle();
        peek(3'd5, v); chk("R8 burst settles on 1", int'(v), 3'b010);
        measure("R8 burst period", 56.0);
        chk("R8 no short phase", glitches, 0);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: got 1 expected 0");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_enable();
        t_change();
        t_disable();
        t_read_default();
        t_timeout();
        t_burst();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule